// File: doc/BRIEF.md
# Inline ECC Address Translator

This block sits in front of a memory whose check codes share the same array as the data. The system sees a flat run of byte addresses covering only data. Physically, every 256-byte data block is followed directly by 32 check bytes, one byte for each 64-bit word. The block turns a system byte address into two physical addresses. The first is where the data byte lives. The second is where the check byte for the enclosing 64-bit word lives. The same folding applies to every address, whether or not the address is protected.

The block also compares the address against a small set of programmable protection windows. Each window has an enable, an inclusive start bound and an inclusive end bound, and both bounds are compared at 256-byte block granularity. When the address falls in an enabled window and the global ECC enable is set, the block raises a protected flag and reports which window matched. The result is registered once, and the downstream ready is passed straight back upstream as the input ready.

Top module: `inline_ecc_xlat`

## Requirements
- R1: For an accepted system address A, the data address output equals floor(A/256)*288 + (A mod 256).
- R2: For an accepted system address A, the check address output equals floor(A/256)*288 + 256 + floor((A mod 256)/8), which places it above the data address by no more than 256.
- R3: When out_ready_i is high at a rising clock edge, the outputs of the following cycle carry the result for the address presented at that edge, and out_valid_o equals the in_valid_i of that edge.
- R4: in_ready_o equals out_ready_i in the same cycle.
- R5: When out_ready_i is low at a rising clock edge, every output holds its value through that edge.
- R6: Window k matches when bits [SYS_AW-1:8] of the address lie between the same bits of its start and end bounds, both bounds included. Bits [7:0] of the bounds are ignored.
- R7: A window whose enable bit (bit k of win_en_i) is low never matches.
- R8: When ecc_en_i is low, prot_o is 0 and hit_idx_o is 0, whatever the window settings.
- R9: If more than one enabled window matches, hit_idx_o reports the lowest index. When prot_o is 0, hit_idx_o is 0.
- R10: The data and check addresses do not depend on the protection result, on ecc_en_i or on the window settings.
- R11: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en_i | input | 1 | Global ECC enable |
| win_en_i | input | NUM_WIN | Per-window enable, bit k for window k |
| win_start_i | input | NUM_WIN*SYS_AW | Inclusive start bounds, window k at bits [k*SYS_AW +: SYS_AW] |
| win_end_i | input | NUM_WIN*SYS_AW | Inclusive end bounds, same packing as the start bounds |
| in_valid_i | input | 1 | Upstream valid |
| in_ready_o | output | 1 | Upstream ready, equal to out_ready_i |
| sys_addr_i | input | SYS_AW | Flat system byte address |
| out_valid_o | output | 1 | Registered valid |
| out_ready_i | input | 1 | Downstream ready and stage enable |
| data_addr_o | output | SYS_AW+1 | Physical data byte address |
| chk_addr_o | output | SYS_AW+1 | Physical check byte address |
| prot_o | output | 1 | Address lies in an enabled window with ECC on |
| hit_idx_o | output | IDX_W | Index of the matching window |

## Verification
Window selection and address folding are computed in the same cycle. The risk is that a window hit at a block edge, or a low-index priority choice between overlapping windows, could disturb the two physical addresses or arrive misaligned with them. The bench places addresses on the first and last byte of window bounds, in overlapping windows, in disabled windows and with ECC turned off. Every output is compared in the same sampled cycle against independently computed folding and window models. Stalls are mixed in at random, so any slip between the two paths shows up as a mismatch against held values.

// File: rtl/inline_ecc_xlat_pkg.sv
package inline_ecc_xlat_pkg;
  // 256-byte data blocks, 8-byte words, one check byte per word
  localparam int BLK_LG  = 8;
  localparam int WORD_LG = 3;
  localparam int CHK_LG  = BLK_LG - WORD_LG;  // 32 check bytes per block

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/inline_ecc_addr_fold.sv
module inline_ecc_addr_fold
  import inline_ecc_xlat_pkg::*;
#(
  parameter int SYS_AW = 32,
  parameter int PHY_AW = SYS_AW + 1
) (
  input  logic [SYS_AW-1:0] sys_addr,
  output logic [PHY_AW-1:0] data_addr,
  output logic [PHY_AW-1:0] chk_addr
);
  logic [PHY_AW-1:0] blk_num;
  logic [PHY_AW-1:0] blk_base;

  // block stride is data plus check bytes: 256 + 32
  assign blk_num   = PHY_AW'(sys_addr[SYS_AW-1:BLK_LG]);
  assign blk_base  = (blk_num << BLK_LG) + (blk_num << CHK_LG);
  assign data_addr = blk_base + PHY_AW'(sys_addr[BLK_LG-1:0]);
  assign chk_addr  = blk_base + PHY_AW'(1 << BLK_LG)
                   + PHY_AW'(sys_addr[BLK_LG-1:WORD_LG]);
endmodule

// File: rtl/inline_ecc_win_match.sv
module inline_ecc_win_match
  import inline_ecc_xlat_pkg::*;
#(
  parameter int SYS_AW  = 32,
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = idx_width(NUM_WIN)
) (
  input  logic [SYS_AW-1:0]         sys_addr,
  input  logic                      ecc_en,
  input  logic [NUM_WIN-1:0]        win_en,
  input  logic [NUM_WIN*SYS_AW-1:0] win_lo,
  input  logic [NUM_WIN*SYS_AW-1:0] win_hi,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx
);
  localparam int BW = SYS_AW - BLK_LG;

  logic [BW-1:0]      addr_blk;
  logic [NUM_WIN-1:0] in_win;

  assign addr_blk = sys_addr[SYS_AW-1:BLK_LG];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [BW-1:0] lo_blk;
    logic [BW-1:0] hi_blk;
    assign lo_blk    = win_lo[g*SYS_AW+BLK_LG +: BW];
    assign hi_blk    = win_hi[g*SYS_AW+BLK_LG +: BW];
    assign in_win[g] = win_en[g] && (addr_blk >= lo_blk) && (addr_blk <= hi_blk);
  end

  // lowest matching index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (in_win[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    if (!ecc_en) begin
      hit     = 1'b0;
      hit_idx = '0;
    end
  end
endmodule

// File: rtl/inline_ecc_stage.sv
module inline_ecc_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/inline_ecc_xlat.sv
module inline_ecc_xlat
  import inline_ecc_xlat_pkg::*;
#(
  parameter int SYS_AW  = 32,
  parameter int NUM_WIN = 3,
  parameter int PHY_AW  = SYS_AW + 1,
  parameter int IDX_W   = idx_width(NUM_WIN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ecc_en_i,
  input  logic [NUM_WIN-1:0]        win_en_i,
  input  logic [NUM_WIN*SYS_AW-1:0] win_start_i,
  input  logic [NUM_WIN*SYS_AW-1:0] win_end_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [SYS_AW-1:0]         sys_addr_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [PHY_AW-1:0]         data_addr_o,
  output logic [PHY_AW-1:0]         chk_addr_o,
  output logic                      prot_o,
  output logic [IDX_W-1:0]          hit_idx_o
);
  localparam int REC_W = 1 + 2 * PHY_AW + 1 + IDX_W;

  logic [PHY_AW-1:0] fold_data;
  logic [PHY_AW-1:0] fold_chk;
  logic              win_hit;
  logic [IDX_W-1:0]  win_idx;
  logic [REC_W-1:0]  rec_d;
  logic [REC_W-1:0]  rec_q;
  logic              stage_en;

  inline_ecc_addr_fold #(.SYS_AW(SYS_AW), .PHY_AW(PHY_AW)) fold_i (
    .sys_addr  (sys_addr_i),
    .data_addr (fold_data),
    .chk_addr  (fold_chk)
  );

  inline_ecc_win_match #(.SYS_AW(SYS_AW), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) match_i (
    .sys_addr (sys_addr_i),
    .ecc_en   (ecc_en_i),
    .win_en   (win_en_i),
    .win_lo   (win_start_i),
    .win_hi   (win_end_i),
    .hit      (win_hit),
    .hit_idx  (win_idx)
  );

  // the whole stage advances only when downstream accepts
  assign stage_en   = out_ready_i;
  assign in_ready_o = out_ready_i;
  assign rec_d      = {in_valid_i, fold_data, fold_chk, win_hit, win_idx};

  inline_ecc_stage #(.W(REC_W)) stage_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (stage_en),
    .d     (rec_d),
    .q     (rec_q)
  );

  assign {out_valid_o, data_addr_o, chk_addr_o, prot_o, hit_idx_o} = rec_q;
endmodule

// File: rtl/inline_ecc_xlat_chk.sv
module inline_ecc_xlat_chk #(
  parameter int NUM_WIN = 3,
  parameter int PHY_AW  = 33,
  parameter int IDX_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ecc_en_i,
  input logic              in_valid_i,
  input logic              out_ready_i,
  input logic              out_valid_o,
  input logic [PHY_AW-1:0] data_addr_o,
  input logic [PHY_AW-1:0] chk_addr_o,
  input logic              prot_o,
  input logic [IDX_W-1:0]  hit_idx_o
);
  p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready_i |=> (out_valid_o == $past(in_valid_i)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready_i |=> ($stable(out_valid_o) && $stable(data_addr_o) &&
                      $stable(chk_addr_o) && $stable(prot_o) && $stable(hit_idx_o)));

  p_ecc_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready_i && !ecc_en_i) |=> (!prot_o && hit_idx_o == '0));

  p_chk_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((chk_addr_o > data_addr_o) &&
                     ((chk_addr_o - data_addr_o) <= PHY_AW'(256))));

  p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_o |-> (int'(hit_idx_o) < NUM_WIN));

  p_idx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_o |-> (hit_idx_o == '0));
endmodule

bind inline_ecc_xlat inline_ecc_xlat_chk #(
  .NUM_WIN(NUM_WIN), .PHY_AW(PHY_AW), .IDX_W(IDX_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ecc_en_i    (ecc_en_i),
  .in_valid_i  (in_valid_i),
  .out_ready_i (out_ready_i),
  .out_valid_o (out_valid_o),
  .data_addr_o (data_addr_o),
  .chk_addr_o  (chk_addr_o),
  .prot_o      (prot_o),
  .hit_idx_o   (hit_idx_o)
);

// File: tb/inline_ecc_xlat_tb_top.sv
`timescale 1ns/1ps
module inline_ecc_xlat_tb_top;
  localparam int AW = 32;
  localparam int NW = 3;
  localparam int PW = 33;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ecc_en;
  logic [NW-1:0] win_en;
  logic [NW*AW-1:0] ws, we;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [AW-1:0] sys_addr;
  logic [PW-1:0] data_addr, chk_addr;
  logic          prot;
  logic [1:0]    hit_idx;

  int checks = 0;
  int errors = 0;

  logic          ev, ep;
  logic [PW-1:0] ed, ec;
  logic [1:0]    ei;

  always #5 clk = ~clk;

  inline_ecc_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .ecc_en_i(ecc_en), .win_en_i(win_en),
    .win_start_i(ws), .win_end_i(we), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .sys_addr_i(sys_addr), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .data_addr_o(data_addr), .chk_addr_o(chk_addr), .prot_o(prot), .hit_idx_o(hit_idx)
  );

  function automatic logic [PW-1:0] f_data(input logic [AW-1:0] a);
    return PW'(a[AW-1:8]) * PW'(288) + PW'(a[7:0]);
  endfunction

  function automatic logic [PW-1:0] f_chk(input logic [AW-1:0] a);
    return PW'(a[AW-1:8]) * PW'(288) + PW'(256) + PW'(a[7:3]);
  endfunction

  function automatic void f_win(input logic [AW-1:0] a, output logic p, output logic [1:0] idx);
    p = 1'b0; idx = 2'd0;
    if (ecc_en) begin
      for (int k = 0; k < NW; k++) begin
        if (!p && win_en[k] && (a[AW-1:8] >= ws[k*AW+8 +: 24]) && (a[AW-1:8] <= we[k*AW+8 +: 24])) begin
          p = 1'b1; idx = 2'(k);
        end
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic set_win(input int k, input logic en, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    win_en[k]        = en;
    ws[k*AW +: AW]   = lo;
    we[k*AW +: AW]   = hi;
  endtask

  task automatic step(input logic [AW-1:0] a, input logic vld, input logic rdy,
                      input string ptag, input string atag);
    @(negedge clk);
    sys_addr = a; in_valid = vld; out_ready = rdy;
    #1;
    check(in_ready == rdy, "R4", "in_ready", 64'(in_ready), 64'(rdy));
    @(posedge clk);
    if (rdy) begin
      ev = vld; ed = f_data(a); ec = f_chk(a); f_win(a, ep, ei);
    end
    #1;
    check(out_valid == ev, rdy ? "R3" : "R5", "valid", 64'(out_valid), 64'(ev));
    check(data_addr == ed, rdy ? atag : "R5", "data_addr", 64'(data_addr), 64'(ed));
    check(chk_addr == ec, rdy ? "R2" : "R5", "chk_addr", 64'(chk_addr), 64'(ec));
    check(prot == ep, rdy ? ptag : "R5", "prot", 64'(prot), 64'(ep));
    check(hit_idx == ei, rdy ? ptag : "R5", "hit_idx", 64'(hit_idx), 64'(ei));
  endtask

  task automatic rand_windows();
    for (int k = 0; k < NW; k++) begin
      logic [AW-1:0] lo, hi;
      lo = (AW'(k) << 30) | (AW'($urandom_range(0, 32'h1FFF_FFFF)));
      hi = lo + AW'($urandom_range(0, 32'h0FFF_FFFF));
      set_win(k, 1'($urandom), lo, hi);
    end
    ecc_en = ($urandom_range(0, 3) != 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1CE5));
    rst_n = 1'b0; ecc_en = 1'b0; win_en = '0; ws = '0; we = '0;
    in_valid = 1'b0; out_ready = 1'b0; sys_addr = '0;
    ev = 0; ed = 0; ec = 0; ep = 0; ei = 0;
    repeat (3) @(negedge clk);
    // R11: outputs cleared in reset
    check(out_valid == 1'b0, "R11", "valid in reset", 64'(out_valid), 0);
    check(data_addr == '0 && chk_addr == '0, "R11", "addr in reset", 64'(data_addr), 0);
    check(prot == 1'b0 && hit_idx == 2'd0, "R11", "prot in reset", 64'(prot), 0);
    rst_n = 1'b1;

    // R1/R2 corner addresses, no windows: R10 translation without protection
    step(32'h0000_0000, 1, 1, "R7", "R10");
    step(32'h0000_00FF, 1, 1, "R7", "R1");
    step(32'h0000_0100, 1, 1, "R7", "R1");
    step(32'hFFFF_FFFF, 1, 1, "R7", "R1");
    step(32'h0000_0107, 0, 1, "R7", "R1");

    // R6: window bounds with nonzero low bits, edges of the range
    ecc_en = 1'b1;
    set_win(0, 1, 32'h0000_10AB, 32'h0000_1F01);
    step(32'h0000_0FFF, 1, 1, "R6", "R1");
    step(32'h0000_1000, 1, 1, "R6", "R1");
    step(32'h0000_1FFF, 1, 1, "R6", "R1");
    step(32'h0000_2000, 1, 1, "R6", "R1");

    // R7: disabled window containing the address
    set_win(1, 0, 32'h0004_0000, 32'h0004_FF00);
    step(32'h0004_1234, 1, 1, "R7", "R1");

    // R9: overlapping windows 1 and 2, lowest index reported
    set_win(1, 1, 32'h0004_0000, 32'h0004_FF00);
    set_win(2, 1, 32'h0004_1000, 32'h0004_2000);
    step(32'h0004_1800, 1, 1, "R9", "R1");
    step(32'h0004_3000, 1, 1, "R9", "R1");

    // R8: ECC off masks the hit; R10 addresses unchanged
    ecc_en = 1'b0;
    step(32'h0004_1800, 1, 1, "R8", "R10");

    // R5: stall with changing input
    ecc_en = 1'b1;
    step(32'h0004_1800, 1, 1, "R9", "R1");
    step(32'h0000_1000, 0, 0, "R5", "R5");
    step(32'h1234_5678, 1, 0, "R5", "R5");
    step(32'h1234_5678, 1, 1, "R6", "R1");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      if (n % 100 == 0) rand_windows();
      if ($urandom_range(0, 1) == 1) begin
        int k;
        k = $urandom_range(0, NW - 1);
        a = ws[k*AW +: AW] + AW'($urandom_range(0, 32'h0FFF_FFFF));
      end else begin
        a = $urandom;
      end
      step(a, 1'($urandom), ($urandom_range(0, 3) != 0),
           ecc_en ? "R6" : "R8", "R1");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule